// File: doc/BRIEF.md
# Touch Press and Long-Press Detector

This block watches a stream of touch samples taken at a regular poll rate. Each sample holds a 32-bit coordinate word and an 8-bit object tag, and a poll strobe marks when a sample is valid. The coordinate value 0x80008000 stands for "nothing touching the panel". Any other value is a live touch. From the change between samples the block reports when a finger lands and when it lifts. It also counts how long the touch was held, in polls.

A configuration input names the object tag of interest. A second count tracks how many polls in a row, starting at the landing poll, the touch stayed on that object. When the finger lifts, the press is classed as long or short. The class depends on that on-object count and a programmable threshold. An early-report mode can announce a long press at the poll where the threshold is reached, without waiting for the lift.

Events come out as single-cycle pulses, one clock after the poll that causes them. The two hold counts are visible at all times.

Top module: `touch_press_detect`

## Requirements
- R1: A coordinate word equal to 0x80008000 means no touch; every other value, including 0x00000000 and 0x80008001, is a touch. During reset and just after it, all event outputs are 0 and both counts are 0.
- R2: `pen_down` pulses high for exactly one cycle, in the cycle after a poll that carries a touch while no press is in progress.
- R3: `pen_up` pulses high for exactly one cycle, in the cycle after a no-touch poll while a press is in progress. Reset leaves the block in the no-press state, so a no-touch poll right after reset gives no `pen_up`.
- R4: `hold_polls` becomes 1 on the landing poll and rises by 1 on every later touch poll of the same press. It keeps its value through the lifting poll and while idle, until the next landing poll.
- R5: `tag_polls` becomes 1 on the landing poll if `tag_in` equals `watch_tag` there, and 0 otherwise. It rises by 1 on each later touch poll with a matching tag, but only while every poll since landing has matched. The first mismatch freezes it for the rest of the press. It never exceeds `hold_polls`.
- R6: With `early_report` low, `long_press` pulses together with `pen_up` when the tag matched on the landing poll and `tag_polls` is at least `long_limit`.
- R7: `short_press` pulses together with `pen_up` when the tag matched on the landing poll and `tag_polls` is below `long_limit`. A press whose landing poll did not match gives neither `short_press` nor `long_press`. `short_press` and `long_press` are never high together.
- R8: With `early_report` high, `long_press` pulses one cycle after the touch poll at which `tag_polls` first reaches `long_limit` (tag matched at landing). It fires at most once per press. At the lifting poll of that press, neither `long_press` nor `short_press` fires.
- R9: Both counts saturate at 2^CNT_W-1 and do not wrap.
- R10: Cycles with `poll_valid` low change no count and produce no event, whatever `coord_in` and `tag_in` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| poll_valid | input | 1 | Marks a valid sample on this cycle |
| coord_in | input | 32 | Sampled coordinate word; 0x80008000 is no touch |
| tag_in | input | 8 | Sampled object tag |
| watch_tag | input | 8 | Tag of the object being monitored |
| long_limit | input | CNT_W | Long-press threshold in on-object polls |
| early_report | input | 1 | 1: report long press when the threshold is reached |
| pen_down | output | 1 | One-cycle pulse: touch landed |
| pen_up | output | 1 | One-cycle pulse: touch lifted |
| short_press | output | 1 | One-cycle pulse: short press on the monitored object |
| long_press | output | 1 | One-cycle pulse: long press on the monitored object |
| hold_polls | output | CNT_W | Polls of the current or last press |
| tag_polls | output | CNT_W | Consecutive on-object polls since landing |

## Verification
The assertions assume that `watch_tag`, `long_limit` and `early_report` change only between presses, or at least not on a poll cycle. The long-press assertion uses the mode value from the cycle of the deciding poll. The bench sets these inputs only while the panel is idle. It separates polls by at least one cycle with the strobe low, which also exercises the rule that unstrobed cycles are ignored. The bench drives `coord_in` with the no-touch word during strobe-low gaps to show that only strobed samples count.

// File: rtl/touch_pkg.sv
`timescale 1ns/1ps
package touch_pkg;

    localparam int COORD_W = 32;
    localparam int TAG_W   = 8;

    // Coordinate value that signals an untouched panel
    localparam logic [COORD_W-1:0] NO_TOUCH_WORD = 32'h8000_8000;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HELD = 1'b1
    } phase_t;

    // Classification of the current cycle's sample
    typedef struct packed {
        logic on_tag;   // strobed touch sample on the monitored tag
        logic down;     // strobed touch while idle
        logic held;     // strobed touch while a press is running
        logic up;       // strobed no-touch while a press is running
    } poll_class_t;

    // Per-press bookkeeping of the decision logic
    typedef struct packed {
        logic first_hit;  // tag matched on the landing poll
        logic run_alive;  // every poll so far stayed on the tag
        logic long_done;  // long press already reported
    } press_ctx_t;

    typedef struct packed {
        logic pen_down;
        logic pen_up;
        logic short_press;
        logic long_press;
    } press_evt_t;

    function automatic logic coord_is_touch(input logic [COORD_W-1:0] word);
        return word != NO_TOUCH_WORD;
    endfunction

endpackage

// File: rtl/touch_edge_classify.sv
`timescale 1ns/1ps
module touch_edge_classify
    import touch_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               poll_i,
    input  logic [COORD_W-1:0] coord_i,
    input  logic [TAG_W-1:0]   tag_i,
    input  logic [TAG_W-1:0]   watch_i,
    output poll_class_t        cls_o
);

    phase_t phase_q;
    logic   touch_now;
    logic   tag_hit;

    always_comb begin
        touch_now    = coord_is_touch(coord_i);
        tag_hit      = (tag_i == watch_i);
        cls_o.on_tag = poll_i && touch_now && tag_hit;
        cls_o.down   = poll_i && touch_now && (phase_q == PH_IDLE);
        cls_o.held   = poll_i && touch_now && (phase_q == PH_HELD);
        cls_o.up     = poll_i && !touch_now && (phase_q == PH_HELD);
    end

    // Previous-sample state starts as "no touch"
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (cls_o.down) begin
            phase_q <= PH_HELD;
        end else if (cls_o.up) begin
            phase_q <= PH_IDLE;
        end
    end

    // R3
    no_spurious_up_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !cls_o.up);

endmodule

// File: rtl/touch_run_counter.sv
`timescale 1ns/1ps
module touch_run_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         seed_i,
    input  logic         step_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] next_o
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_comb begin
        next_o = cnt_q;
        if (start_i) begin
            next_o = {{(W-1){1'b0}}, seed_i};
        end else if (step_i && (cnt_q != CNT_MAX)) begin
            next_o = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= next_o;
        end
    end

    assign cnt_o = cnt_q;

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/touch_press_judge.sv
`timescale 1ns/1ps
module touch_press_judge
    import touch_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  poll_class_t  cls_i,
    input  logic [W-1:0] tag_next_i,
    input  logic [W-1:0] limit_i,
    input  logic         early_i,
    output logic         run_alive_o,
    output press_evt_t   evt_o
);

    press_ctx_t ctx_q, ctx_d;
    press_evt_t evt_q, evt_d;
    logic       reached;

    always_comb begin
        ctx_d   = ctx_q;
        evt_d   = '0;
        reached = (tag_next_i >= limit_i);
        if (cls_i.down) begin
            evt_d.pen_down  = 1'b1;
            ctx_d.first_hit = cls_i.on_tag;
            ctx_d.run_alive = cls_i.on_tag;
            ctx_d.long_done = 1'b0;
            if (early_i && cls_i.on_tag && reached) begin
                evt_d.long_press = 1'b1;
                ctx_d.long_done  = 1'b1;
            end
        end else if (cls_i.held) begin
            if (!cls_i.on_tag) begin
                ctx_d.run_alive = 1'b0;
            end
            if (early_i && ctx_q.first_hit && !ctx_q.long_done && reached) begin
                evt_d.long_press = 1'b1;
                ctx_d.long_done  = 1'b1;
            end
        end else if (cls_i.up) begin
            evt_d.pen_up = 1'b1;
            if (ctx_q.first_hit) begin
                if (reached) begin
                    evt_d.long_press = !ctx_q.long_done;
                end else begin
                    evt_d.short_press = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            evt_q <= '0;
        end else begin
            ctx_q <= ctx_d;
            evt_q <= evt_d;
        end
    end

    assign run_alive_o = ctx_q.run_alive;
    assign evt_o       = evt_q;

    // R7
    excl_class_chk: assert property (@(posedge clk) disable iff (rst)
        !(evt_q.short_press && evt_q.long_press));

    // R7
    short_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        evt_q.short_press |-> evt_q.pen_up);

    // R6
    long_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_q.long_press && !$past(early_i)) |-> evt_q.pen_up);

    // R8
    one_long_chk: assert property (@(posedge clk) disable iff (rst)
        (ctx_q.long_done && !cls_i.down) |=> !evt_q.long_press);

endmodule

// File: rtl/touch_press_detect.sv
`timescale 1ns/1ps
module touch_press_detect
    import touch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             poll_valid,
    input  logic [31:0]      coord_in,
    input  logic [7:0]       tag_in,
    input  logic [7:0]       watch_tag,
    input  logic [CNT_W-1:0] long_limit,
    input  logic             early_report,
    output logic             pen_down,
    output logic             pen_up,
    output logic             short_press,
    output logic             long_press,
    output logic [CNT_W-1:0] hold_polls,
    output logic [CNT_W-1:0] tag_polls
);

    poll_class_t      cls;
    press_evt_t       evt;
    logic             run_alive;
    logic [CNT_W-1:0] hold_next;
    logic [CNT_W-1:0] tag_next;

    touch_edge_classify u_classify (
        .clk    (clk),
        .rst    (rst),
        .poll_i (poll_valid),
        .coord_i(coord_in),
        .tag_i  (tag_in),
        .watch_i(watch_tag),
        .cls_o  (cls)
    );

    touch_run_counter #(.W(CNT_W)) u_hold_cnt (
        .clk    (clk),
        .rst    (rst),
        .start_i(cls.down),
        .seed_i (1'b1),
        .step_i (cls.held),
        .cnt_o  (hold_polls),
        .next_o (hold_next)
    );

    touch_run_counter #(.W(CNT_W)) u_tag_cnt (
        .clk    (clk),
        .rst    (rst),
        .start_i(cls.down),
        .seed_i (cls.on_tag),
        .step_i (cls.held && cls.on_tag && run_alive),
        .cnt_o  (tag_polls),
        .next_o (tag_next)
    );

    touch_press_judge #(.W(CNT_W)) u_judge (
        .clk        (clk),
        .rst        (rst),
        .cls_i      (cls),
        .tag_next_i (tag_next),
        .limit_i    (long_limit),
        .early_i    (early_report),
        .run_alive_o(run_alive),
        .evt_o      (evt)
    );

    assign pen_down    = evt.pen_down;
    assign pen_up      = evt.pen_up;
    assign short_press = evt.short_press;
    assign long_press  = evt.long_press;

    // R5
    tag_le_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tag_next <= hold_next);

    // R10
    idle_poll_chk: assert property (@(posedge clk) disable iff (rst)
        !poll_valid |=> ($stable(hold_polls) && $stable(tag_polls) &&
                         !pen_down && !pen_up && !short_press && !long_press));

endmodule

// File: tb/touch_press_detect_bench.sv
`timescale 1ns/1ps
module touch_press_detect_bench;

    localparam int          CNT_W = 6;
    localparam logic [31:0] NT    = 32'h8000_8000;
    localparam logic [31:0] PA    = 32'h0040_0030;
    localparam logic [31:0] PB    = 32'h0041_0031;

    logic             clk = 1'b0;
    logic             rst;
    logic             poll_valid;
    logic [31:0]      coord_in;
    logic [7:0]       tag_in;
    logic [7:0]       watch_tag;
    logic [CNT_W-1:0] long_limit;
    logic             early_report;
    logic             pen_down, pen_up, short_press, long_press;
    logic [CNT_W-1:0] hold_polls, tag_polls;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic s_down, s_up, s_short, s_long;

    always #2 clk = ~clk;

    touch_press_detect #(.CNT_W(CNT_W)) u_touch_press_detect (
        .clk(clk), .rst(rst), .poll_valid(poll_valid), .coord_in(coord_in),
        .tag_in(tag_in), .watch_tag(watch_tag), .long_limit(long_limit),
        .early_report(early_report), .pen_down(pen_down), .pen_up(pen_up),
        .short_press(short_press), .long_press(long_press),
        .hold_polls(hold_polls), .tag_polls(tag_polls)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_evt(input string req, input int d, input int u, input int s, input int l);
        chk({req, " pen_down"}, s_down, d);
        chk({req, " pen_up"}, s_up, u);
        chk({req, " short_press"}, s_short, s);
        chk({req, " long_press"}, s_long, l);
    endtask

    // One strobed sample, then one strobe-low gap with the no-touch word
    task automatic do_poll(input logic [31:0] c, input logic [7:0] t);
        @(negedge clk);
        poll_valid = 1'b1;
        coord_in   = c;
        tag_in     = t;
        @(negedge clk);
        poll_valid = 1'b0;
        coord_in   = NT;
        s_down = pen_down; s_up = pen_up; s_short = short_press; s_long = long_press;
    endtask

    task automatic setup(input logic [7:0] w, input int lim, input logic early);
        @(negedge clk);
        watch_tag    = w;
        long_limit   = CNT_W'(lim);
        early_report = early;
    endtask

    task automatic t_reset;
        rst = 1'b1; poll_valid = 1'b0; coord_in = NT; tag_in = '0;
        watch_tag = 8'h22; long_limit = 6'd5; early_report = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset events", {pen_down, pen_up, short_press, long_press}, 0);
        chk("R1 reset hold", hold_polls, 0);
        chk("R1 reset tag", tag_polls, 0);
    endtask

    task automatic t_idle_after_reset;
        do_poll(NT, 8'h22);
        chk_evt("R3 no-touch after reset", 0, 0, 0, 0);
    endtask

    task automatic t_short;
        setup(8'h22, 5, 1'b0);
        do_poll(PA, 8'h22);
        chk_evt("R2 landing", 1, 0, 0, 0);
        chk("R4 hold at landing", hold_polls, 1);
        chk("R5 tag at landing", tag_polls, 1);
        chk("R2 single cycle", pen_down, 1);
        @(negedge clk);
        chk("R2 pulse gone", pen_down, 0);
        do_poll(PB, 8'h22);
        do_poll(PA, 8'h22);
        chk_evt("R2 held no event", 0, 0, 0, 0);
        chk("R4 hold counting", hold_polls, 3);
        chk("R5 tag counting", tag_polls, 3);
        do_poll(NT, 8'h00);
        chk_evt("R7 short release", 0, 1, 0 + 1, 0);
        chk("R4 hold kept at lift", hold_polls, 3);
        @(negedge clk);
        chk("R3 pen_up single cycle", pen_up, 0);
        chk("R4 hold kept idle", hold_polls, 3);
    endtask

    task automatic t_long;
        setup(8'h22, 3, 1'b0);
        do_poll(32'h0000_0000, 8'h22);
        chk_evt("R1 zero word is touch", 1, 0, 0, 0);
        for (int i = 0; i < 3; i++) do_poll(32'h8000_8001, 8'h22);
        chk("R5 tag count four", tag_polls, 4);
        chk_evt("R6 no early report", 0, 0, 0, 0);
        do_poll(NT, 8'h22);
        chk_evt("R6 long release", 0, 1, 0, 1);
    endtask

    task automatic t_offtag;
        setup(8'h22, 2, 1'b0);
        do_poll(PA, 8'h22);
        do_poll(PA, 8'h33);
        chk("R5 frozen on mismatch", tag_polls, 1);
        chk("R4 hold off-tag", hold_polls, 2);
        do_poll(PB, 8'h22);
        chk("R5 stays frozen", tag_polls, 1);
        chk("R4 hold three", hold_polls, 3);
        do_poll(NT, 8'h22);
        chk_evt("R7 short after leaving tag", 0, 1, 1, 0);
    endtask

    task automatic t_nohit;
        setup(8'h22, 1, 1'b0);
        do_poll(PA, 8'h33);
        chk("R5 landing off tag", tag_polls, 0);
        do_poll(PA, 8'h22);
        chk("R5 no count after late match", tag_polls, 0);
        do_poll(NT, 8'h22);
        chk_evt("R7 no class without landing hit", 0, 1, 0, 0);
    endtask

    task automatic t_early;
        setup(8'h22, 3, 1'b1);
        do_poll(PA, 8'h22);
        chk_evt("R8 landing no long", 1, 0, 0, 0);
        do_poll(PA, 8'h22);
        chk_evt("R8 second poll no long", 0, 0, 0, 0);
        do_poll(PA, 8'h22);
        chk_evt("R8 long at threshold", 0, 0, 0, 1);
        do_poll(PA, 8'h22);
        chk_evt("R8 long only once", 0, 0, 0, 0);
        do_poll(NT, 8'h22);
        chk_evt("R8 lift after early long", 0, 1, 0, 0);
        setup(8'h22, 5, 1'b0);
    endtask

    task automatic t_strobe;
        setup(8'h22, 5, 1'b0);
        do_poll(PA, 8'h22);
        do_poll(PA, 8'h22);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            coord_in = (i % 2 == 0) ? NT : PB;
            tag_in   = 8'h22;
            chk("R10 no pen_up unstrobed", pen_up, 0);
            chk("R10 hold unchanged", hold_polls, 2);
        end
        coord_in = NT;
        do_poll(NT, 8'h22);
        chk_evt("R10 strobed lift after gap", 0, 1, 1, 0);
    endtask

    task automatic t_sat;
        setup(8'h22, 63, 1'b0);
        do_poll(PA, 8'h22);
        for (int i = 0; i < 69; i++) do_poll(PB, 8'h22);
        chk("R9 hold saturates", hold_polls, 63);
        chk("R9 tag saturates", tag_polls, 63);
        do_poll(NT, 8'h22);
        chk_evt("R9 long at saturated limit", 0, 1, 0, 1);
    endtask

    initial begin
        t_reset();
        t_idle_after_reset();
        t_short();
        t_long();
        t_offtag();
        t_nohit();
        t_early();
        t_strobe();
        t_sat();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule